// File: doc/BRIEF.md
# Cascadable Serial Fault Readout Port

This block moves the fault state of four load-switch channels out over a slow three-wire serial link that an external controller drives. Each channel reports a 2-bit fault code. When the controller pulls the frame select low, the block takes a snapshot of all codes in one step. On every rising edge of the serial clock it then moves the snapshot out one bit at a time. The serial input is shifted in behind the snapshot, so several ports can be wired output-to-input and read in one long frame.

While the frame select is idle high, the serial output acts as an active-low "fault pending" line that the controller can watch like an interrupt. The output is open-drain: it is shown as a level plus a drive-enable that is asserted only when the line is pulled low. When a frame ends, the block sends a one-cycle clear to the fault registers of each channel whose code was read out. A channel is not cleared if its code changed after the snapshot, so a fault that arrives during a frame stays pending. All three pins are brought into the system clock domain through two-flop synchronizers before any edge is detected.

Top module: `diag_shift_port`

## Requirements
- R1: While no frame is open, `sdo_oe` is 1 and `sdo_val` is 0 when `fault_any` is 1. When `fault_any` is 0, `sdo_oe` is 0 and `sdo_val` is 1.
- R2: A falling edge of `sel_n` copies `fault_code` into the shift register. Bit 0 of the snapshot appears on `sdo_val` before the first rising edge of `sclk`.
- R3: Each rising edge of `sclk` inside a frame advances the output by one bit, in the order snapshot bit 0, 1, … 7. Channel k (k = 0..3) owns bits 2k (sent first) and 2k+1. The code pairs, written as {first, second}, are: 11 no fault, 10 overload, 01 open load, 00 short to ground.
- R4: After the eight snapshot bits, the output shows the bits taken from `sdi` on the earlier rising edges of `sclk`, in the order they were taken.
- R5: Rising edges of `sclk` while `sel_n` is high leave the shift register unchanged. A later frame still starts with snapshot bit 0.
- R6: A rising edge of `sel_n` that ends a frame pulses `fault_clr[k]` high for exactly one cycle for each channel k whose snapshot code was not 11 and whose present code still equals the snapshot.
- R7: A channel whose code changed during the frame is not cleared by the rising edge that ends that frame.
- R8: After reset, no frame is open and no clear is pulsed, and the output follows R1.
- R9: `sdo_oe` is never 1 while `sdo_val` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Frame select from the controller, active low, asynchronous |
| sclk | input | 1 | Serial shift clock, asynchronous |
| sdi | input | 1 | Serial data from the upstream device in the chain |
| fault_any | input | 1 | High when any channel has a latched fault |
| fault_code | input | 8 | Per-channel 2-bit codes, channel k on bits 2k+1:2k |
| sdo_val | output | 1 | Serial output level |
| sdo_oe | output | 1 | Pull-down enable for the open-drain serial output |
| fault_clr | output | 4 | One-cycle clear pulse per channel |

## Verification
The bench targets the boundary between the snapshot bits and the chained bits. A design with an off-by-one shift would repeat a snapshot bit or drop the first `sdi` bit there. It toggles `sclk` while no frame is open: a design that shifts without checking the frame state would start the next frame at a later bit. It changes fault codes in the middle of a frame. A design that clears every channel on the closing edge would lose the new fault, and the bench sees this as an unexpected `fault_clr` pulse. It also checks the idle output against `fault_any` on both polarities, which exposes an inverted pending flag or an output that drives the line high.

// File: rtl/diag_shift_port.sv
module diag_shift_port #(
  parameter int CHANNELS   = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_n,
  input  logic                  sclk,
  input  logic                  sdi,
  input  logic                  fault_any,
  input  logic [2*CHANNELS-1:0] fault_code,
  output logic                  sdo_val,
  output logic                  sdo_oe,
  output logic [CHANNELS-1:0]   fault_clr
);
  localparam int W = 2 * CHANNELS;

  logic [SYNC_DEPTH-1:0] sel_sync, ck_sync, di_sync;
  logic                  sel_prev, ck_prev;
  logic                  in_frame;
  logic [W-1:0]          shreg, snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sync <= '1;
      ck_sync  <= '0;
      di_sync  <= '1;
      sel_prev <= 1'b1;
      ck_prev  <= 1'b0;
    end else begin
      sel_sync <= {sel_sync[SYNC_DEPTH-2:0], sel_n};
      ck_sync  <= {ck_sync[SYNC_DEPTH-2:0], sclk};
      di_sync  <= {di_sync[SYNC_DEPTH-2:0], sdi};
      sel_prev <= sel_sync[SYNC_DEPTH-1];
      ck_prev  <= ck_sync[SYNC_DEPTH-1];
    end
  end

  wire sel_s    = sel_sync[SYNC_DEPTH-1];
  wire sel_fall = sel_prev & ~sel_s;
  wire sel_rise = ~sel_prev & sel_s;
  wire ck_rise  = ~ck_prev & ck_sync[SYNC_DEPTH-1];
  wire di_s     = di_sync[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      shreg    <= '1;
      snap     <= '1;
    end else if (sel_fall) begin
      in_frame <= 1'b1;
      shreg    <= fault_code;
      snap     <= fault_code;
    end else if (sel_rise) begin
      in_frame <= 1'b0;
    end else if (in_frame && ck_rise) begin
      shreg    <= {di_s, shreg[W-1:1]};
    end
  end

  logic [CHANNELS-1:0] clr_next;
  genvar k;
  generate
    for (k = 0; k < CHANNELS; k++) begin : g_clr
      assign clr_next[k] = in_frame && sel_rise &&
                           (snap[2*k+1 -: 2] != 2'b11) &&
                           (fault_code[2*k+1 -: 2] == snap[2*k+1 -: 2]);

      p_clear_unchanged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr[k] |-> $past(fault_code[2*k+1 -: 2]) == $past(snap[2*k+1 -: 2]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_clr <= '0;
    else        fault_clr <= clr_next;
  end

  assign sdo_val = in_frame ? shreg[0] : ~fault_any;
  assign sdo_oe  = ~sdo_val;

  p_open_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !sdo_val);

  p_clear_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_clr) |=> (fault_clr == '0));

  p_clear_at_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_clr) |-> !in_frame && $past(in_frame));

  p_shift_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && ck_rise && !sel_rise) |=> shreg[W-2:0] == $past(shreg[W-1:1]));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !sel_fall) |=> $stable(shreg));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |=> in_frame && shreg == $past(fault_code));
endmodule

// File: tb/diag_shift_port_bench.sv
module diag_shift_port_bench;
  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sclk = 0, sdi = 1, fault_any = 0;
  logic [7:0] fault_code = 8'hFF;
  logic sdo_val, sdo_oe;
  logic [3:0] fault_clr;
  logic [3:0] clr_seen = '0;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  diag_shift_port u_diag_shift_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .fault_any(fault_any), .fault_code(fault_code),
    .sdo_val(sdo_val), .sdo_oe(sdo_oe), .fault_clr(fault_clr));

  always @(posedge clk) clr_seen <= clr_seen | fault_clr;

  // {fault_code, four chained bits}
  localparam logic [11:0] VEC [6] = '{
    {8'hFF, 4'b1010}, {8'hFE, 4'b0110}, {8'h6D, 4'b0001},
    {8'h00, 4'b1111}, {8'hA5, 4'b1000}, {8'h5A, 4'b0101}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    sclk = 1; wait_cyc(8);
    sclk = 0; wait_cyc(8);
  endtask

  function automatic logic [3:0] exp_clr(input logic [7:0] v);
    for (int k = 0; k < 4; k++) exp_clr[k] = (v[2*k+1 -: 2] != 2'b11);
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    check(sdo_oe == 0 && sdo_val == 1 && fault_clr == 0, "R8 reset", {sdo_oe, sdo_val}, 2'b01);
    rst_n = 1; wait_cyc(4);
    check(sdo_oe == 0 && sdo_val == 1, "R8 idle after reset", {sdo_oe, sdo_val}, 2'b01);

    foreach (VEC[t]) begin
      logic [7:0] v = VEC[t][11:4];
      logic [3:0] ch = VEC[t][3:0];
      logic [11:0] got = '0;
      fault_code = v; fault_any = (v != 8'hFF); wait_cyc(6);
      check(sdo_oe == fault_any && sdo_val == !fault_any, "R1 idle flag", {sdo_oe, sdo_val}, {fault_any, !fault_any});
      if (t == 2) begin
        pulse_sclk(); pulse_sclk(); pulse_sclk();
        check(sdo_oe == fault_any, "R5 idle sclk ignored", sdo_oe, fault_any);
      end
      clr_seen = '0;
      sel_n = 0; wait_cyc(8);
      check(sdo_val == v[0], "R2 first bit before clock", sdo_val, v[0]);
      for (int i = 0; i < 12; i++) begin
        got[i] = sdo_val;
        sdi = ch[i % 4];
        pulse_sclk();
      end
      check(got[7:0] == v, t == 2 ? "R3 R5 frame order" : "R3 frame order", got[7:0], v);
      check(got[11:8] == ch, "R4 chained bits", got[11:8], ch);
      check(clr_seen == 0, "R6 no clear in frame", clr_seen, 0);
      sdi = 1; sel_n = 1; wait_cyc(10);
      check(clr_seen == exp_clr(v), "R6 clear mask", clr_seen, exp_clr(v));
    end

    // R7: ch0 open, ch1 overload at snapshot; during frame ch0 -> short, ch2 -> overload
    fault_code = 8'hF6; fault_any = 1; wait_cyc(6);
    clr_seen = '0;
    sel_n = 0; wait_cyc(8);
    pulse_sclk();
    fault_code = 8'hD4; wait_cyc(4);
    sel_n = 1; wait_cyc(10);
    check(clr_seen == 4'b0010, "R7 changed channels kept", clr_seen, 4'b0010);
    check(sdo_oe == 1 && sdo_val == 0, "R7 pending flag stays", {sdo_oe, sdo_val}, 2'b10);

    // R6 single-cycle pulse width
    fault_code = 8'hFE; wait_cyc(4);
    sel_n = 0; wait_cyc(8);
    sel_n = 1;
    begin
      int width = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (fault_clr != 0) width++;
      end
      check(width == 1, "R6 pulse width", width, 1);
    end

    fault_code = 8'hFF; fault_any = 0; wait_cyc(4);
    check(sdo_oe == 0 && sdo_val == 1, "R1 released", {sdo_oe, sdo_val}, 2'b01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule